// File: doc/BRIEF.md
# Voice Message Record/Playback Sequencer

This block is the digital control core of a single-chip voice message recorder. It accepts an active-low chip enable, a power-down level, a playback/record select and a 9-bit bus. That bus carries either a start row address or a set of mode flags. The block keeps a row pointer into an abstract sample store and issues one write strobe per sample tick while it records. A register bank holds one end-of-message bit per row. That bank decides where playback halts, skips ahead, wraps around or carries on.

Recording clears the marker bit of each row it writes. When a recording is stopped, the marker bit of the last row written is set. During playback the marker bit of the row being played is tested on each tick. A hit raises the end-of-message pulse, and the active mode flags then decide what the pointer does next. When the pointer runs off the last row, the block enters an overflow state. It stays there until power-down returns it to row 0. An auxiliary-source select tells the analog path when it may route the external input to the speaker.

All inputs are synchronous to the clock. A free-running divider, a fixed divide-by-two followed by a parameterized ratio, sets the sample-tick rate.

Top module: `voice_seq_core`

## Requirements
- R1: When bits 8 and 7 of `addr_mode` are both 1 at a start, bits 6:0 are taken as mode flags: bit 0 cueing, bit 1 marker merge, bit 3 looping, bit 4 consecutive, bit 5 level-activated; bits 2 and 6 are ignored. Otherwise all nine bits are the start row.
- R2: A start is taken only in the idle state with `pd` low, on a clock where `ce_n` is low after being high on the previous clock. `play_sel` is sampled then, 1 meaning playback and 0 meaning record. After reset `row_addr` is 0, `row_wr` is 0, and `eom_n`, `ovf_n` are 1.
- R3: While recording, `row_wr` is 1 for one clock on each sample tick with `row_addr` at the row being written, and the pointer then advances by one. Recording stops when `ce_n` or `pd` is high. On stop, the marker of the last row written is set. Rows that are written get their markers cleared.
- R4: In direct playback, a tick on a row whose marker is set drives `eom_n` low for PULSE_CYC clocks starting the next clock. Playback then stops with `row_addr` held, unless `ce_n` is still low, in which case it continues to the next row.
- R5: A tick on row 511 that is recorded, or played without a marker, enters overflow. `ovf_n` is low for PULSE_CYC clocks and then equals `ce_n`. Only `pd` high leaves overflow, returning to idle at row 0.
- R6: `pd` high forces idle and row 0 on the next clock. A mode start begins at row 0 if its direction differs from the previous start; otherwise it begins at the current pointer.
- R7: A playback start with the cueing flag moves the pointer one row per clock, with no EOM pulse, to the row after the next set marker, then goes idle.
- R8: A record start with the merge flag at a nonzero row clears the marker of the row just before it.
- R9: With the looping flag, a marker hit during playback sends the pointer to row 0 and playback continues.
- R10: In mode playback without looping, a marker hit stops playback. The pointer moves to the next row with the consecutive flag, or to row 0 without it.
- R11: With the level-activated flag, playback stops on the first clock that `ce_n` is high. The pointer goes to row 0 unless the consecutive flag is set, in which case it holds.
- R12: `aux_sel` is 1 exactly when `ce_n` is high, `play_sel` is high, and no playback or cueing is running.
- R13: Sample ticks occur once every 2*TICK_RATIO clocks from reset release, and the pointer moves at most once per tick while recording or playing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Active-low chip enable |
| pd | input | 1 | Power-down / pointer reset |
| play_sel | input | 1 | 1 = playback, 0 = record |
| addr_mode | input | 9 | Start row or mode flags |
| row_addr | output | 9 | Current row pointer |
| row_wr | output | 1 | Sample write strobe for `row_addr` |
| eom_n | output | 1 | Active-low end-of-message pulse |
| ovf_n | output | 1 | Active-low overflow indication |
| aux_sel | output | 1 | Select the auxiliary audio source |

## Verification
The properties assume that `ce_n`, `pd` and `play_sel` are synchronous to `clk`. They also assume that TICK_RATIO is at least 1, so write strobes can never fall on neighbouring clocks. The bench changes every input only on the falling clock edge. It always leaves `ce_n` high for at least one clock between starts, and it releases `pd` only while `ce_n` is high, so a start is never taken by accident. Outputs are compared every clock against a behavioural model of the requirements.

// File: rtl/vsq_pkg.sv
// Shared types for the voice sequencer: controller states and decoded mode flags.
// Assumes the mode flag field is the low seven bits of the address/mode bus.
package vsq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REC,
        ST_PLAY,
        ST_CUE,
        ST_OVF
    } vsq_state_e;

    typedef struct packed {
        logic level_act;
        logic consec;
        logic looping;
        logic merge;
        logic cueing;
    } vsq_flags_t;

    // Map the raw flag field onto the named mode flags.
    function automatic vsq_flags_t vsq_decode(input logic [6:0] raw);
        vsq_flags_t f;
        f.cueing    = raw[0];
        f.merge     = raw[1];
        f.looping   = raw[3];
        f.consec    = raw[4];
        f.level_act = raw[5];
        return f;
    endfunction

endpackage

// File: rtl/vsq_tick_gen.sv
// Sample tick generator: divides the clock by two, then by RATIO.
// Assumes RATIO >= 1; the tick is a one-clock pulse every 2*RATIO clocks.
module vsq_tick_gen #(
    parameter int RATIO = 64
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (RATIO > 1) ? $clog2(RATIO) : 1;
    localparam logic [CW-1:0] CMAX = CW'(RATIO - 1);

    logic          half_q;
    logic [CW-1:0] cnt_q;

    // Toggle the halving stage and count its enables up to RATIO.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            half_q <= ~half_q;
            if (half_q) begin
                cnt_q <= (cnt_q == CMAX) ? '0 : cnt_q + 1'b1;
            end
        end
    end

    assign tick = half_q && (cnt_q == CMAX);
endmodule

// File: rtl/vsq_marker_mem.sv
// End-of-message marker bank: one bit per row, one write port, one async read.
// Assumes at most one write per clock; bits clear on reset.
module vsq_marker_mem #(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic              wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic              rdata
);
    localparam int ROWS = 1 << ADDR_W;

    logic [ROWS-1:0] bits_q;

    // Update the addressed marker bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else if (we) begin
            bits_q[waddr] <= wdata;
        end
    end

    assign rdata = bits_q[raddr];
endmodule

// File: rtl/vsq_pulse.sv
// Low-going pulse stretcher: a load holds out_n low for CYC clocks.
// Assumes CYC >= 1; a new load restarts the count.
module vsq_pulse #(
    parameter int CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic out_n
);
    localparam int CW = $clog2(CYC + 1);

    logic [CW-1:0] cnt_q;

    // Reload on request, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CW'(CYC);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign out_n = (cnt_q == '0);
endmodule

// File: rtl/vsq_ctrl.sv
// Sequencer controller: start decode, record/playback/cue state machine,
// pointer policy per mode and marker bank writes.
// Assumes all inputs are synchronous to clk and ADDR_W >= 9.
module vsq_ctrl
    import vsq_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              ce_n,
    input  logic              pd,
    input  logic              play_sel,
    input  logic [ADDR_W-1:0] addr_mode,
    input  logic              mark_rd,
    output logic [ADDR_W-1:0] ptr,
    output vsq_state_e        state,
    output logic              mk_we,
    output logic [ADDR_W-1:0] mk_waddr,
    output logic              mk_wdata,
    output logic              eom_load,
    output logic              ovf_load
);
    localparam logic [ADDR_W-1:0] LAST = '1;

    vsq_state_e        state_q, state_d;
    logic [ADDR_W-1:0] ptr_q, ptr_d;
    logic              ce_q;
    logic              mode_q, mode_d;
    vsq_flags_t        flg_q, flg_d;
    logic              last_pr_q, last_pr_d;
    logic              wrote_q, wrote_d;

    logic              ce_fall;
    logic              st_is_mode;
    vsq_flags_t        st_flg;
    logic [ADDR_W-1:0] st_ptr;

    // Decode what a start would do this clock.
    always_comb begin
        ce_fall    = ce_q && !ce_n;
        st_is_mode = addr_mode[ADDR_W-1] && addr_mode[ADDR_W-2];
        st_flg     = st_is_mode ? vsq_decode(addr_mode[6:0]) : '0;
        if (st_is_mode) begin
            st_ptr = (play_sel != last_pr_q) ? '0 : ptr_q;
        end else begin
            st_ptr = addr_mode;
        end
    end

    // Next-state, pointer and marker-write decisions.
    always_comb begin
        state_d   = state_q;
        ptr_d     = ptr_q;
        mode_d    = mode_q;
        flg_d     = flg_q;
        last_pr_d = last_pr_q;
        wrote_d   = wrote_q;
        mk_we     = 1'b0;
        mk_waddr  = ptr_q;
        mk_wdata  = 1'b0;
        eom_load  = 1'b0;
        ovf_load  = 1'b0;
        if (pd) begin
            if (state_q == ST_REC && wrote_q) begin
                mk_we    = 1'b1;
                mk_waddr = ptr_q - 1'b1;
                mk_wdata = 1'b1;
            end
            state_d = ST_IDLE;
            ptr_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (ce_fall) begin
                        mode_d    = st_is_mode;
                        flg_d     = st_flg;
                        last_pr_d = play_sel;
                        ptr_d     = st_ptr;
                        wrote_d   = 1'b0;
                        if (!play_sel) begin
                            state_d = ST_REC;
                            if (st_flg.merge && st_ptr != '0) begin
                                mk_we    = 1'b1;
                                mk_waddr = st_ptr - 1'b1;
                            end
                        end else if (st_flg.cueing) begin
                            state_d = ST_CUE;
                        end else begin
                            state_d = ST_PLAY;
                        end
                    end
                end
                ST_REC: begin
                    if (ce_n) begin
                        if (wrote_q) begin
                            mk_we    = 1'b1;
                            mk_waddr = ptr_q - 1'b1;
                            mk_wdata = 1'b1;
                        end
                        state_d = ST_IDLE;
                    end else if (tick) begin
                        mk_we   = 1'b1;
                        wrote_d = 1'b1;
                        if (ptr_q == LAST) begin
                            state_d  = ST_OVF;
                            ovf_load = 1'b1;
                        end else begin
                            ptr_d = ptr_q + 1'b1;
                        end
                    end
                end
                ST_PLAY: begin
                    if (flg_q.level_act && ce_n) begin
                        state_d = ST_IDLE;
                        if (!flg_q.consec) ptr_d = '0;
                    end else if (tick) begin
                        if (mark_rd) begin
                            eom_load = 1'b1;
                            if (flg_q.looping) begin
                                ptr_d = '0;
                            end else if (!mode_q && !ce_n) begin
                                if (ptr_q == LAST) begin
                                    state_d  = ST_OVF;
                                    ovf_load = 1'b1;
                                end else begin
                                    ptr_d = ptr_q + 1'b1;
                                end
                            end else begin
                                state_d = ST_IDLE;
                                if (mode_q) ptr_d = flg_q.consec ? ptr_q + 1'b1 : '0;
                            end
                        end else if (ptr_q == LAST) begin
                            state_d  = ST_OVF;
                            ovf_load = 1'b1;
                        end else begin
                            ptr_d = ptr_q + 1'b1;
                        end
                    end
                end
                ST_CUE: begin
                    if (mark_rd) begin
                        ptr_d   = ptr_q + 1'b1;
                        state_d = ST_IDLE;
                    end else if (ptr_q == LAST) begin
                        state_d  = ST_OVF;
                        ovf_load = 1'b1;
                    end else begin
                        ptr_d = ptr_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Register controller state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            ptr_q     <= '0;
            ce_q      <= 1'b1;
            mode_q    <= 1'b0;
            flg_q     <= '0;
            last_pr_q <= 1'b1;
            wrote_q   <= 1'b0;
        end else begin
            state_q   <= state_d;
            ptr_q     <= ptr_d;
            ce_q      <= ce_n;
            mode_q    <= mode_d;
            flg_q     <= flg_d;
            last_pr_q <= last_pr_d;
            wrote_q   <= wrote_d;
        end
    end

    assign ptr   = ptr_q;
    assign state = state_q;
endmodule

// File: rtl/voice_seq_core.sv
// Voice message sequencer top: ties the tick divider, controller, marker bank
// and pulse stretchers together and forms the output flags.
// Assumes inputs synchronous to clk; the address/mode bus is ADDR_W bits.
module voice_seq_core
    import vsq_pkg::*;
#(
    parameter int ADDR_W     = 9,
    parameter int TICK_RATIO = 64,
    parameter int PULSE_CYC  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              pd,
    input  logic              play_sel,
    input  logic [ADDR_W-1:0] addr_mode,
    output logic [ADDR_W-1:0] row_addr,
    output logic              row_wr,
    output logic              eom_n,
    output logic              ovf_n,
    output logic              aux_sel
);
    logic              tick;
    logic [ADDR_W-1:0] ptr;
    vsq_state_e        state;
    logic              mk_we, mk_wdata, mark_rd;
    logic [ADDR_W-1:0] mk_waddr;
    logic              eom_load, ovf_load, ovf_pulse_n;

    vsq_tick_gen #(.RATIO(TICK_RATIO)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    vsq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ce_n(ce_n), .pd(pd),
        .play_sel(play_sel), .addr_mode(addr_mode), .mark_rd(mark_rd),
        .ptr(ptr), .state(state), .mk_we(mk_we), .mk_waddr(mk_waddr),
        .mk_wdata(mk_wdata), .eom_load(eom_load), .ovf_load(ovf_load)
    );

    vsq_marker_mem #(.ADDR_W(ADDR_W)) u_marks (
        .clk(clk), .rst_n(rst_n), .we(mk_we), .waddr(mk_waddr),
        .wdata(mk_wdata), .raddr(ptr), .rdata(mark_rd)
    );

    vsq_pulse #(.CYC(PULSE_CYC)) u_eom (
        .clk(clk), .rst_n(rst_n), .load(eom_load), .out_n(eom_n)
    );

    vsq_pulse #(.CYC(PULSE_CYC)) u_ovf (
        .clk(clk), .rst_n(rst_n), .load(ovf_load), .out_n(ovf_pulse_n)
    );

    // Output flags from state and live inputs.
    always_comb begin
        row_addr = ptr;
        row_wr   = (state == ST_REC) && tick;
        ovf_n    = (state != ST_OVF) || (ovf_pulse_n && ce_n);
        aux_sel  = ce_n && play_sel && (state != ST_PLAY) && (state != ST_CUE);
    end
endmodule

// File: rtl/vsq_checker.sv
// Port-level properties of the voice sequencer, bound to every instance.
// Assumes synchronous inputs and TICK_RATIO >= 1.
module vsq_checker #(
    parameter int ADDR_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              pd,
    input logic              play_sel,
    input logic [ADDR_W-1:0] row_addr,
    input logic              row_wr,
    input logic              ovf_n,
    input logic              aux_sel
);
    localparam logic [ADDR_W-1:0] LAST = '1;

    assert_wr_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (row_wr && !ce_n && !pd && row_addr != LAST) |=> (row_addr == $past(row_addr) + 1'b1));

    assert_pd_clears_ovf_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pd |=> ovf_n);

    assert_pd_home_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pd |=> (row_addr == '0));

    assert_aux_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
        aux_sel |-> (ce_n && play_sel));

    assert_wr_spacing_R13: assert property (@(posedge clk) disable iff (!rst_n)
        row_wr |=> !row_wr);
endmodule

bind voice_seq_core vsq_checker #(.ADDR_W(ADDR_W)) u_vsq_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .pd(pd), .play_sel(play_sel),
    .row_addr(row_addr), .row_wr(row_wr), .ovf_n(ovf_n), .aux_sel(aux_sel)
);

// File: tb/voice_seq_core_bench.sv
`timescale 1ns/100ps
module voice_seq_core_bench;
    localparam int AW    = 9;
    localparam int RATIO = 2;
    localparam int PULSE = 3;
    localparam int ROWS  = 512;
    localparam int PER   = 2 * RATIO;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1;
    logic          pd = 1'b0;
    logic          play_sel = 1'b1;
    logic [AW-1:0] addr_mode = '0;
    logic [AW-1:0] row_addr;
    logic          row_wr, eom_n, ovf_n, aux_sel;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 0;
    string cur_req  = "R2";

    always #2.5 clk = ~clk;

    voice_seq_core #(.ADDR_W(AW), .TICK_RATIO(RATIO), .PULSE_CYC(PULSE)) u_voice_seq_core (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .pd(pd), .play_sel(play_sel),
        .addr_mode(addr_mode), .row_addr(row_addr), .row_wr(row_wr),
        .eom_n(eom_n), .ovf_n(ovf_n), .aux_sel(aux_sel)
    );

    // Behavioural reference: 0 idle, 1 record, 2 play, 3 cue, 4 overflow.
    int m_st, m_ptr, m_j, m_eomc, m_ovfc;
    bit m_mark[ROWS];
    bit m_ceq, m_mode, m_lastpr, m_wrote;
    bit f_cue, f_merge, f_loop, f_cons, f_lvl;

    function automatic int wrap(input int v);
        return (v % ROWS + ROWS) % ROWS;
    endfunction

    always @(posedge clk) begin
        bit tk, fall, eld, old, ismode;
        int sp;
        if (!rst_n) begin
            m_st = 0; m_ptr = 0; m_j = 0; m_eomc = 0; m_ovfc = 0;
            m_ceq = 1; m_mode = 0; m_lastpr = 1; m_wrote = 0;
            f_cue = 0; f_merge = 0; f_loop = 0; f_cons = 0; f_lvl = 0;
            foreach (m_mark[i]) m_mark[i] = 0;
        end else begin
            tk = (m_j % PER) == PER - 1;
            m_j++;
            fall = m_ceq && !ce_n;
            eld = 0; old = 0;
            if (pd) begin
                if (m_st == 1 && m_wrote) m_mark[wrap(m_ptr - 1)] = 1;
                m_st = 0; m_ptr = 0;
            end else if (m_st == 0) begin
                if (fall) begin
                    ismode = addr_mode[8] && addr_mode[7];
                    f_cue = ismode && addr_mode[0];
                    f_merge = ismode && addr_mode[1];
                    f_loop = ismode && addr_mode[3];
                    f_cons = ismode && addr_mode[4];
                    f_lvl = ismode && addr_mode[5];
                    if (ismode) sp = (play_sel != m_lastpr) ? 0 : m_ptr;
                    else sp = int'(addr_mode);
                    m_mode = ismode; m_lastpr = play_sel; m_wrote = 0; m_ptr = sp;
                    if (!play_sel) begin
                        m_st = 1;
                        if (f_merge && sp != 0) m_mark[sp - 1] = 0;
                    end else m_st = f_cue ? 3 : 2;
                end
            end else if (m_st == 1) begin
                if (ce_n) begin
                    if (m_wrote) m_mark[wrap(m_ptr - 1)] = 1;
                    m_st = 0;
                end else if (tk) begin
                    m_mark[m_ptr] = 0; m_wrote = 1;
                    if (m_ptr == ROWS - 1) begin m_st = 4; old = 1; end
                    else m_ptr++;
                end
            end else if (m_st == 2) begin
                if (f_lvl && ce_n) begin
                    m_st = 0;
                    if (!f_cons) m_ptr = 0;
                end else if (tk) begin
                    if (m_mark[m_ptr]) begin
                        eld = 1;
                        if (f_loop) m_ptr = 0;
                        else if (!m_mode && !ce_n) begin
                            if (m_ptr == ROWS - 1) begin m_st = 4; old = 1; end
                            else m_ptr++;
                        end else begin
                            m_st = 0;
                            if (m_mode) m_ptr = f_cons ? wrap(m_ptr + 1) : 0;
                        end
                    end else if (m_ptr == ROWS - 1) begin m_st = 4; old = 1; end
                    else m_ptr++;
                end
            end else if (m_st == 3) begin
                if (m_mark[m_ptr]) begin m_ptr = wrap(m_ptr + 1); m_st = 0; end
                else if (m_ptr == ROWS - 1) begin m_st = 4; old = 1; end
                else m_ptr++;
            end
            if (eld) m_eomc = PULSE; else if (m_eomc > 0) m_eomc--;
            if (old) m_ovfc = PULSE; else if (m_ovfc > 0) m_ovfc--;
            m_ceq = ce_n;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s act=%0d exp=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    // Compare every output to the reference shortly after each falling edge.
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            check(cur_req, "row_addr", int'(row_addr), m_ptr);
            check((m_st == 1) ? "R3" : "R13", "row_wr", int'(row_wr),
                  int'((m_st == 1) && ((m_j % PER) == PER - 1)));
            check((cur_req == "R2") ? "R4" : cur_req, "eom_n", int'(eom_n), int'(m_eomc == 0));
            check("R5", "ovf_n", int'(ovf_n), int'(m_st != 4 || (m_ovfc == 0 && ce_n)));
            check("R12", "aux_sel", int'(aux_sel),
                  int'(ce_n && play_sel && m_st != 2 && m_st != 3));
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start(input bit pr, input logic [AW-1:0] a, input int hold);
        @(negedge clk);
        addr_mode = a; play_sel = pr; ce_n = 1'b0;
        repeat (hold) @(negedge clk);
        ce_n = 1'b1;
    endtask

    task automatic power_down();
        @(negedge clk); pd = 1'b1;
        @(negedge clk); pd = 1'b0;
        idle(2);
    endtask

    function automatic logic [AW-1:0] modew(input logic [6:0] f);
        return {2'b11, f};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R2", "reset row_addr", int'(row_addr), 0);
        check("R2", "reset row_wr", int'(row_wr), 0);
        check("R2", "reset eom_n", int'(eom_n), 1);
        check("R2", "reset ovf_n", int'(ovf_n), 1);
        @(negedge clk); rst_n = 1'b1;
        idle(5);
        cur_req = "R1"; start(1'b0, 9'd10, 21); idle(6);         // direct record rows from 10
        cur_req = "R4"; start(1'b1, 9'd10, 2); idle(40);         // direct play stops at marker
        cur_req = "R4"; start(1'b1, 9'd10, 60); idle(2100);      // held low: passes the marker
        cur_req = "R5"; ce_n = 1'b0; idle(3); ce_n = 1'b1; idle(3);
        power_down();
        cur_req = "R5"; start(1'b0, 9'd505, 40); idle(4);        // record overflow
        ce_n = 1'b0; idle(2); ce_n = 1'b1; idle(2);
        power_down();
        cur_req = "R6"; start(1'b0, modew(7'h00), 11); idle(4);  // mode record from 0
        cur_req = "R6"; start(1'b0, modew(7'h00), 11); idle(4);  // continues same direction
        cur_req = "R8"; start(1'b0, modew(7'h02), 11); idle(4);  // merge with previous
        cur_req = "R10"; start(1'b1, modew(7'h00), 2); idle(60); // direction change -> row 0
        cur_req = "R10"; start(1'b1, modew(7'h10), 2); idle(60); // consecutive
        cur_req = "R8"; start(1'b1, modew(7'h10), 2); idle(80);  // plays through merged marker
        power_down();
        cur_req = "R7"; start(1'b1, modew(7'h01), 2); idle(30);  // cue to next message
        cur_req = "R7"; start(1'b1, modew(7'h01), 2); idle(30);
        power_down();
        cur_req = "R9"; start(1'b1, modew(7'h08), 2); idle(60);  // looping
        power_down();
        cur_req = "R11"; start(1'b1, modew(7'h20), 7); idle(6);  // level, restart from 0
        cur_req = "R11"; start(1'b1, modew(7'h30), 7); idle(6);  // level with consecutive
        cur_req = "R11"; start(1'b1, modew(7'h30), 9); idle(6);
        power_down();
        cur_req = "R12"; play_sel = 1'b0; idle(4); play_sel = 1'b1; idle(4);
        cur_req = "R1"; start(1'b1, 9'h140, 2); idle(20);        // only bit 8 set: direct row 320
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog act=running exp=finished");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule